// File: doc/BRIEF.md
# Dual Timer/Counter

This block holds two 16-bit timer/counters, each built from a low byte and a high byte that software can read and write. Each unit advances either on a qualified internal tick (`tick` high in a cycle) or on a falling edge of its own external count input, which is first brought into the clock domain. Each unit has a run bit and an optional gate that lets it advance only while its gate pin is high. On overflow, each unit sets a sticky flag that software clears.

Four counting modes are offered. There is a 13-bit mode, made of the high byte and the low five bits of the low byte. There is a full 16-bit mode. There is an 8-bit mode in which the low byte reloads from the high byte. There is also a split mode, available on timer 0 only, that turns timer 0 into two independent 8-bit counters. In split mode the second half of timer 0 takes over the run bit and the flag of timer 1, and timer 1 keeps counting without its run bit. Overflows are flagged for every reload value, including the all-ones cases.

The register map uses a 3-bit address. Address 0 is the control register: bit 0 is run0, bit 1 is run1, bit 2 is flag0 and bit 3 is flag1. Address 1 is the mode register: bits [3:0] belong to timer 0 and bits [7:4] to timer 1. Within each nibble, bits [1:0] are the mode (0 = 13-bit, 1 = 16-bit, 2 = 8-bit reload, 3 = split), bit 2 is the source select (0 = ticks, 1 = external edges) and bit 3 is the gate enable. Addresses 2, 3, 4 and 5 are the low byte of timer 0, the high byte of timer 0, the low byte of timer 1 and the high byte of timer 1. Other addresses read as zero.

Top module: `dual_tmr_ctr`

## Requirements
- R1: After reset, the control register, the mode register and all four count bytes read 0.
- R2: A write to the mode register or to a count byte is read back unchanged at the same address while the units are stopped.
- R3: In mode 1, a unit counts as a 16-bit value {high,low}. Stepping from FFFFh wraps to 0000h and sets the unit's flag (control bit 2 for timer 0, bit 3 for timer 1). After software writes FFFFh, the next count therefore sets the flag.
- R4: In mode 2, the low byte counts, and on stepping from FFh it loads the high byte and sets the flag on every such overflow. With a high byte of FFh, every count overflows, leaves the low byte at FFh and sets the flag.
- R5: In mode 0, the low five bits of the low byte carry into the high byte, and the low byte's upper three bits hold their value. Stepping with the high byte at FFh and the low five bits at 1Fh overflows to zero and sets the flag.
- R6: With source select 0, a unit counts cycles with `tick` high and ignores its external input. With source select 1, it counts synchronised falling edges of its external input and ignores `tick`.
- R7: A unit counts only while its run bit is 1 and either its gate enable is 0 or its synchronised gate pin is 1.
- R8: With timer 0 in mode 3, the low byte of timer 0 is an 8-bit counter that uses run0 and sets flag0. The high byte of timer 0 counts ticks only while run1 is 1, and its overflow sets flag1.
- R9: With timer 0 in mode 3, timer 1 counts independently of run1 in both tick and edge source. Its overflow sets no flag. Timer 1 placed in mode 3 holds its count.
- R10: Flags stay set through writes to other addresses. A control-register write with a flag bit of 0 clears that flag. A hardware set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Internal count qualifier, one count per cycle it is high |
| extCnt0 | input | 1 | External count input of timer 0 (asynchronous) |
| extCnt1 | input | 1 | External count input of timer 1 (asynchronous) |
| gatePin0 | input | 1 | Gate pin of timer 0 (asynchronous) |
| gatePin1 | input | 1 | Gate pin of timer 1 (asynchronous) |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address for read and write |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data (combinational) |
| flagOut0 | output | 1 | Overflow flag 0 |
| flagOut1 | output | 1 | Overflow flag 1 |

## Verification
Each counting mode is started from preloaded byte values just below, at and far from the wrap point, which separates a wrong carry position from a wrong reload or a missing flag. Reload values of FFh and a preload of FFFFh are the patterns where a flag raised only on a count change would stay silent. Split mode is tried with run1 on and off, and with timer 1 on ticks and on external edges, to tell apart run1 steering the high byte of timer 0 from run1 still stopping timer 1. Gate and source select are toggled against the same stimulus, so that a count with the wrong qualifier shows up as an extra or missing step.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam logic [1:0] MODE_13     = 2'd0;
  localparam logic [1:0] MODE_16     = 2'd1;
  localparam logic [1:0] MODE_RELOAD = 2'd2;
  localparam logic [1:0] MODE_SPLIT  = 2'd3;

  localparam int ADR_CTRL = 0;
  localparam int ADR_MODE = 1;
  localparam int ADR_LO0  = 2;
  localparam int ADR_HI0  = 3;
  localparam int ADR_LO1  = 4;
  localparam int ADR_HI1  = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic       incA;   // timer 0 (whole, or low byte in split mode)
    logic       incB;   // timer 0 high byte in split mode
    logic       incC;   // timer 1
    logic       wrLo0;
    logic       wrHi0;
    logic       wrLo1;
    logic       wrHi1;
    logic [1:0] mode0;
    logic [1:0] mode1;
  } strobe_t;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (!rstN) pipe <= '0;
      else       pipe <= {pipe[STAGES-2:0], din[i]};
    end
    assign dout[i] = pipe[STAGES-1];
  end

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int W           = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [1:0]        extCnt,
  input  logic [1:0]        gatePin,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [W-1:0]      regWrData,
  input  logic              ovfA,
  input  logic              ovfB,
  input  logic              ovfC,
  output strobe_t           stb,
  output logic [7:0]        modeReg,
  output logic              run0,
  output logic              run1,
  output logic              flag0,
  output logic              flag1
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(ADR_MODE);
  localparam logic [ADDR_W-1:0] A_LO0  = ADDR_W'(ADR_LO0);
  localparam logic [ADDR_W-1:0] A_HI0  = ADDR_W'(ADR_HI0);
  localparam logic [ADDR_W-1:0] A_LO1  = ADDR_W'(ADR_LO1);
  localparam logic [ADDR_W-1:0] A_HI1  = ADDR_W'(ADR_HI1);

  logic [3:0] synced;
  logic [1:0] extLvl, gateLvl, extPrev, extFall;
  logic [1:0] cSel, gateEn, evt, pinOk;
  logic [1:0] mdF [2];
  logic       split, wrCtrl, wrMode, set1;

  tmr_sync #(.N(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({gatePin, extCnt}),
    .dout (synced)
  );

  assign extLvl  = synced[1:0];
  assign gateLvl = synced[3:2];

  always_ff @(posedge clk) begin
    if (!rstN) extPrev <= '0;
    else       extPrev <= extLvl;
  end
  assign extFall = extPrev & ~extLvl;

  for (genvar i = 0; i < 2; i++) begin : g_unit
    assign mdF[i]    = modeReg[4*i +: 2];
    assign cSel[i]   = modeReg[4*i + 2];
    assign gateEn[i] = modeReg[4*i + 3];
    assign evt[i]    = cSel[i] ? extFall[i] : tick;
    assign pinOk[i]  = ~gateEn[i] | gateLvl[i];
  end

  assign split  = (mdF[0] == MODE_SPLIT);
  assign wrCtrl = regWrEn && (regAddr == A_CTRL);
  assign wrMode = regWrEn && (regAddr == A_MODE);

  always_comb begin
    stb       = '0;
    stb.mode0 = mdF[0];
    stb.mode1 = mdF[1];
    stb.incA  = run0 & pinOk[0] & evt[0];
    stb.incB  = split & run1 & tick;
    // in split mode timer 1 no longer waits on run1
    stb.incC  = (split | run1) & pinOk[1] & evt[1] & (mdF[1] != MODE_SPLIT);
    stb.wrLo0 = regWrEn && (regAddr == A_LO0);
    stb.wrHi0 = regWrEn && (regAddr == A_HI0);
    stb.wrLo1 = regWrEn && (regAddr == A_LO1);
    stb.wrHi1 = regWrEn && (regAddr == A_HI1);
  end

  assign set1 = split ? ovfB : ovfC;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      run0    <= 1'b0;
      run1    <= 1'b0;
      flag0   <= 1'b0;
      flag1   <= 1'b0;
      modeReg <= '0;
    end else begin
      if (wrCtrl) begin
        run0 <= regWrData[0];
        run1 <= regWrData[1];
      end
      flag0 <= ovfA | (wrCtrl ? regWrData[2] : flag0);
      flag1 <= set1 | (wrCtrl ? regWrData[3] : flag1);
      if (wrMode) modeReg <= regWrData[7:0];
    end
  end

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int W     = 8,
  parameter int PRE_W = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobe_t      stb,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] lo0,
  output logic [W-1:0] hi0,
  output logic [W-1:0] lo1,
  output logic [W-1:0] hi1,
  output logic         ovfA,
  output logic         ovfB,
  output logic         ovfC
);

  localparam logic [PRE_W:0] ONE_P = {{PRE_W{1'b0}}, 1'b1};
  localparam logic [W:0]     ONE_B = {{W{1'b0}}, 1'b1};
  localparam logic [2*W:0]   ONE_S = {{(2*W){1'b0}}, 1'b1};

  // returns {overflow, nextHi, nextLo}
  function automatic logic [2*W:0] stepCount(input logic [1:0] md,
                                             input logic [W-1:0] lo,
                                             input logic [W-1:0] hi);
    logic [PRE_W:0] p;
    logic [W:0]     h;
    logic [W:0]     l;
    logic [2*W:0]   s;
    logic [2*W:0]   r;
    p = {1'b0, lo[PRE_W-1:0]} + ONE_P;
    h = {1'b0, hi} + {{W{1'b0}}, p[PRE_W]};
    l = {1'b0, lo} + ONE_B;
    s = {1'b0, hi, lo} + ONE_S;
    case (md)
      MODE_13:     r = {h[W], h[W-1:0], lo[W-1:PRE_W], p[PRE_W-1:0]};
      MODE_16:     r = s;
      MODE_RELOAD: r = l[W] ? {1'b1, hi, hi} : {1'b0, hi, l[W-1:0]};
      default:     r = {l[W], hi, l[W-1:0]};
    endcase
    return r;
  endfunction

  logic [2*W:0] nxt0, nxt1;
  logic [W:0]   hb;
  logic         split;

  assign nxt0  = stepCount(stb.mode0, lo0, hi0);
  assign nxt1  = stepCount(stb.mode1, lo1, hi1);
  assign hb    = {1'b0, hi0} + ONE_B;
  assign split = (stb.mode0 == MODE_SPLIT);

  assign ovfA = stb.incA & nxt0[2*W];
  assign ovfB = stb.incB & hb[W];
  assign ovfC = stb.incC & nxt1[2*W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lo0 <= '0;
      hi0 <= '0;
      lo1 <= '0;
      hi1 <= '0;
    end else begin
      if (stb.wrLo0)     lo0 <= wrData;
      else if (stb.incA) lo0 <= nxt0[W-1:0];

      if (stb.wrHi0)                 hi0 <= wrData;
      else if (stb.incB)             hi0 <= hb[W-1:0];
      else if (stb.incA && !split)   hi0 <= nxt0[2*W-1:W];

      if (stb.wrLo1)     lo1 <= wrData;
      else if (stb.incC) lo1 <= nxt1[W-1:0];

      if (stb.wrHi1)     hi1 <= wrData;
      else if (stb.incC) hi1 <= nxt1[2*W-1:W];
    end
  end

endmodule

// File: rtl/dual_tmr_ctr.sv
module dual_tmr_ctr
  import tmr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_W       = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              extCnt0,
  input  logic              extCnt1,
  input  logic              gatePin0,
  input  logic              gatePin1,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              flagOut0,
  output logic              flagOut1
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(ADR_MODE);
  localparam logic [ADDR_W-1:0] A_LO0  = ADDR_W'(ADR_LO0);
  localparam logic [ADDR_W-1:0] A_HI0  = ADDR_W'(ADR_HI0);
  localparam logic [ADDR_W-1:0] A_LO1  = ADDR_W'(ADR_LO1);
  localparam logic [ADDR_W-1:0] A_HI1  = ADDR_W'(ADR_HI1);

  strobe_t           stb;
  logic [7:0]        modeReg;
  logic              run0, run1, flag0, flag1;
  logic              ovfA, ovfB, ovfC;
  logic [DATA_W-1:0] lo0, hi0, lo1, hi1;

  tmr_ctrl #(.W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .extCnt    ({extCnt1, extCnt0}),
    .gatePin   ({gatePin1, gatePin0}),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .ovfA      (ovfA),
    .ovfB      (ovfB),
    .ovfC      (ovfC),
    .stb       (stb),
    .modeReg   (modeReg),
    .run0      (run0),
    .run1      (run1),
    .flag0     (flag0),
    .flag1     (flag1)
  );

  tmr_datapath #(.W(DATA_W), .PRE_W(PRE_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (regWrData),
    .lo0    (lo0),
    .hi0    (hi0),
    .lo1    (lo1),
    .hi1    (hi1),
    .ovfA   (ovfA),
    .ovfB   (ovfB),
    .ovfC   (ovfC)
  );

  always_comb begin
    regRdData = '0;
    case (regAddr)
      A_CTRL:  regRdData[3:0] = {flag1, flag0, run1, run0};
      A_MODE:  regRdData[7:0] = modeReg;
      A_LO0:   regRdData = lo0;
      A_HI0:   regRdData = hi0;
      A_LO1:   regRdData = lo1;
      A_HI1:   regRdData = hi1;
      default: regRdData = '0;
    endcase
  end

  assign flagOut0 = flag0;
  assign flagOut1 = flag1;

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int W      = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input strobe_t           stb,
  input logic [W-1:0]      lo0,
  input logic [W-1:0]      hi0,
  input logic [W-1:0]      lo1,
  input logic [W-1:0]      hi1,
  input logic [1:0]        t1Opts,
  input logic              run1,
  input logic              flag0
);

  localparam logic [2*W-1:0] ONE16 = {{(2*W-1){1'b0}}, 1'b1};

  // R3: all-ones 16-bit value wraps to zero and raises flag0
  a_r3_ffff_wraps: assert property (@(posedge clk) disable iff (!rstN)
    (stb.mode0 == MODE_16 && stb.incA && {hi0, lo0} == '1 && !stb.wrLo0 && !stb.wrHi0)
    |=> ({hi0, lo0} == '0 && flag0));

  // R4: reload value FFh still overflows and flags
  a_r4_ff_reload_flags: assert property (@(posedge clk) disable iff (!rstN)
    (stb.mode0 == MODE_RELOAD && stb.incA && hi0 == '1 && lo0 == '1 && !stb.wrLo0 && !stb.wrHi0)
    |=> (lo0 == '1 && flag0));

  // R8: split-mode high byte stays put while run1 is off
  a_r8_th0_held: assert property (@(posedge clk) disable iff (!rstN)
    (stb.mode0 == MODE_SPLIT && !run1 && !stb.wrHi0) |=> $stable(hi0));

  // R9: timer 1 keeps counting ticks in split mode whatever run1 is
  a_r9_t1_free: assert property (@(posedge clk) disable iff (!rstN)
    (stb.mode0 == MODE_SPLIT && stb.mode1 == MODE_16 && tick && t1Opts == 2'b00
     && !stb.wrLo1 && !stb.wrHi1)
    |=> ({hi1, lo1} == $past({hi1, lo1}) + ONE16));

  // R10: flag0 is sticky without a control write
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flag0 && !(regWrEn && regAddr == ADDR_W'(ADR_CTRL))) |=> flag0);

endmodule

bind dual_tmr_ctr tmr_chk #(.W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .tick    (tick),
  .regWrEn (regWrEn),
  .regAddr (regAddr),
  .stb     (stb),
  .lo0     (lo0),
  .hi0     (hi0),
  .lo1     (lo1),
  .hi1     (hi1),
  .t1Opts  (modeReg[7:6]),
  .run1    (run1),
  .flag0   (flag0)
);

// File: tb/dual_tmr_ctr_tb.sv
`timescale 1ns/1ps
module dual_tmr_ctr_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       extCnt0 = 1'b0, extCnt1 = 1'b0;
  logic       gatePin0 = 1'b0, gatePin1 = 1'b0;
  logic       regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       flagOut0, flagOut1;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dual_tmr_ctr u_dut (
    .clk(clk), .rstN(rstN), .tick(tick),
    .extCnt0(extCnt0), .extCnt1(extCnt1),
    .gatePin0(gatePin0), .gatePin1(gatePin1),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .flagOut0(flagOut0), .flagOut1(flagOut1)
  );

  // {mode, preLo, preHi, ticks, expLo, expHi, expFlag0}
  localparam int NV = 9;
  localparam logic [42:0] VECS [NV] = '{
    {2'd1, 8'hFE, 8'hFF, 8'd1,   8'hFF, 8'hFF, 1'b0},  // R3 one short of wrap
    {2'd1, 8'hFF, 8'hFF, 8'd1,   8'h00, 8'h00, 1'b1},  // R3 FFFFh preload
    {2'd1, 8'hFF, 8'h00, 8'd1,   8'h00, 8'h01, 1'b0},  // R3 byte carry
    {2'd2, 8'hFE, 8'h80, 8'd3,   8'h81, 8'h80, 1'b1},  // R4 reload path
    {2'd2, 8'hFF, 8'hFF, 8'd1,   8'hFF, 8'hFF, 1'b1},  // R4 reload FFh
    {2'd0, 8'h1F, 8'h00, 8'd1,   8'h00, 8'h01, 1'b0},  // R5 carry at bit 5
    {2'd0, 8'hFF, 8'hFF, 8'd1,   8'hE0, 8'h00, 1'b1},  // R5 wrap, upper bits kept
    {2'd3, 8'hFF, 8'h10, 8'd1,   8'h00, 8'h10, 1'b1},  // R8 split low byte
    {2'd1, 8'h00, 8'h00, 8'd200, 8'hC8, 8'h00, 1'b0}   // R3 long run
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) extCnt0 = 1'b1; else extCnt1 = 1'b1;
    repeat (4) @(negedge clk);
    if (which == 0) extCnt0 = 1'b0; else extCnt1 = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); check("R1 reset", v, 8'h00);
    end

    // R2 readback while stopped
    wr(3'd1, 8'h5A); rd(3'd1, v); check("R2 mode", v, 8'h5A);
    wr(3'd4, 8'h3C); rd(3'd4, v); check("R2 lo1", v, 8'h3C);
    wr(3'd1, 8'h00);

    // table of mode vectors on timer 0
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, 8'h00);
      wr(3'd1, {6'd0, VECS[i][42:41]});
      wr(3'd2, VECS[i][40:33]);
      wr(3'd3, VECS[i][32:25]);
      wr(3'd0, 8'h01);
      ticks(int'(VECS[i][24:17]));
      rd(3'd2, v); check($sformatf("R3-5,R8 vec%0d lo", i), v, VECS[i][16:9]);
      rd(3'd3, v); check($sformatf("R3-5,R8 vec%0d hi", i), v, VECS[i][8:1]);
      rd(3'd0, v); check($sformatf("R3-5,R8 vec%0d flag0", i), {7'd0, v[2]}, {7'd0, VECS[i][0]});
    end

    // R4 repeated overflows with reload FFh
    wr(3'd0, 8'h00); wr(3'd1, 8'h02); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    for (int k = 0; k < 3; k++) begin
      wr(3'd0, 8'h01);
      ticks(1);
      rd(3'd0, v); check("R4 FFh each overflow flag", {7'd0, v[2]}, 8'h01);
      rd(3'd2, v); check("R4 FFh lo", v, 8'hFF);
    end

    // R6 external source, tick ignored
    wr(3'd0, 8'h00); wr(3'd1, 8'h05); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd0, 8'h01);
    ticks(5);
    rd(3'd2, v); check("R6 tick ignored", v, 8'h00);
    for (int k = 0; k < 3; k++) pulse(0);
    rd(3'd2, v); check("R6 ext edges", v, 8'h03);

    // R7 gate
    wr(3'd0, 8'h00); wr(3'd1, 8'h09); wr(3'd2, 8'h00);
    gatePin0 = 1'b0;
    wr(3'd0, 8'h01);
    repeat (4) @(negedge clk);
    ticks(4);
    rd(3'd2, v); check("R7 gate low", v, 8'h00);
    gatePin0 = 1'b1;
    repeat (4) @(negedge clk);
    ticks(4);
    rd(3'd2, v); check("R7 gate high", v, 8'h04);
    wr(3'd0, 8'h00);
    ticks(2);
    rd(3'd2, v); check("R7 run off", v, 8'h04);

    // R8 split: run1 drives high byte of timer 0, flag1
    wr(3'd1, 8'h13); wr(3'd2, 8'h00); wr(3'd3, 8'hFF);
    wr(3'd0, 8'h02);
    ticks(1);
    rd(3'd3, v); check("R8 hi0 wrap", v, 8'h00);
    rd(3'd0, v); check("R8 flags", v & 8'h0C, 8'h08);
    rd(3'd2, v); check("R8 lo0 idle run0 off", v, 8'h00);

    // R9 timer 1 free of run1 in split mode
    wr(3'd0, 8'h00); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    ticks(5);
    rd(3'd4, v); check("R9 t1 ticks run1 off", v, 8'h05);
    rd(3'd3, v); check("R9 hi0 held run1 off", v, 8'h00);
    wr(3'd1, 8'h53); wr(3'd4, 8'h00);
    pulse(1); pulse(1);
    rd(3'd4, v); check("R9 t1 ext edges run1 off", v, 8'h02);
    ticks(3);
    rd(3'd4, v); check("R6 t1 tick ignored", v, 8'h02);
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    pulse(1);
    rd(3'd4, v); check("R9 t1 wrapped", v, 8'h00);
    rd(3'd0, v); check("R9 no flag1", v & 8'h08, 8'h00);
    wr(3'd1, 8'h33); wr(3'd4, 8'h00);
    ticks(3);
    rd(3'd4, v); check("R9 t1 mode3 holds", v, 8'h00);

    // contrast: outside split mode run1 gates timer 1
    wr(3'd1, 8'h10); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    ticks(3);
    rd(3'd4, v); check("R7 t1 run1 off", v, 8'h00);
    wr(3'd0, 8'h02);
    ticks(3);
    rd(3'd4, v); check("R7 t1 run1 on", v, 8'h03);
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    ticks(1);
    rd(3'd0, v); check("R3 t1 flag1", v & 8'h08, 8'h08);

    // R10 sticky flags
    wr(3'd2, 8'h00);
    rd(3'd0, v); check("R10 kept", v & 8'h08, 8'h08);
    check("R10 pin", {7'd0, flagOut1}, 8'h01);
    wr(3'd0, 8'h02);
    rd(3'd0, v); check("R10 cleared", v & 8'h08, 8'h00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule